// File: doc/BRIEF.md
# Rectifier On-Time Expansion Limiter

This block governs the gate of a synchronous rectifier switch in an isolated converter. It caps how much the rectifier's conduction time can grow from one switching cycle to the next. Each cycle begins on a start pulse. It ends on the earliest of three events: the turn-off request coming from the zero-crossing predictors, expiry of a per-cycle budget, or a global disable. The budget equals the previous completed on-time plus a fixed step, so a sudden jump in the predicted on-time cannot turn into a long, unsafe gate pulse in a single cycle.

The block also keeps a debounced line-voltage state built from a raw high-line comparator bit. A move to high line needs a long stable run. A move back to low line needs only a short one. Any of the following resets the stored on-time to zero, so the next cycle is held to the minimum width and the on-time ramps up again step by step:

- an accepted line change,
- the release of reset,
- a pulse marking exit from idle mode.

The on-time is measured in clock cycles. Every width and time is a parameter expressed in clock cycles. At 50 MHz, the 500 ns step and minimum are 25 cycles each, the 18 ms rise debounce is 900,000 cycles, and the 15 µs fall debounce is 750 cycles.

Top module: `srl_expansion_limiter`

## Requirements
- R1: While reset is asserted and after its release with no stimulus, `gate_out` is 0, `line_high` is 0 (low line) and `last_ontime` is 0.
- R2: A `gate_start` pulse sampled while the gate is off and `gate_dis` is 0 raises `gate_out` at that clock edge. A `gate_start` sampled while `gate_dis` is 1 is ignored and the gate stays low.
- R3: The width of each cycle in clock cycles never exceeds max(MIN_CYC, `last_ontime` + STEP_CYC), where `last_ontime` is the stored value while the cycle runs. Without a turn-off request, the cycle lasts exactly that budget.
- R4: An `off_req` sampled while the gate is on and the width so far is at least MIN_CYC ends the cycle at that edge. The width is then the number of cycles counted up to that edge.
- R5: An `off_req` arriving before MIN_CYC cycles have elapsed does not end the cycle early. The gate stays on for exactly MIN_CYC cycles.
- R6: `gate_dis` forces `gate_out` low in the same cycle, without waiting for a clock edge. A cycle ended this way leaves `last_ontime` unchanged.
- R7: At the edge where a cycle ends through `off_req` or through budget expiry, `last_ontime` takes that cycle's width.
- R8: `line_high` goes from 0 to 1 only after `line_raw` has been sampled 1 on LH_CYC consecutive edges. Any 0 sample in between restarts the count.
- R9: `line_high` goes from 1 to 0 after `line_raw` has been sampled 0 on HL_CYC consecutive edges.
- R10: An accepted line change clears `last_ontime` to 0. If a cycle is running, it ends at the same edge without being recorded, so the next cycle is held to the minimum width.
- R11: An `idle_exit` pulse clears `last_ontime` to 0. If a cycle is running, it ends at the same edge without being recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| gate_start | input | 1 | Pulse that begins a conduction cycle |
| off_req | input | 1 | Earliest turn-off request from the predictors |
| line_raw | input | 1 | Raw high-line comparator bit (1 = high line) |
| idle_exit | input | 1 | Pulse marking exit from idle mode |
| gate_dis | input | 1 | Global gate disable |
| gate_out | output | 1 | Final rectifier gate command |
| line_high | output | 1 | Debounced line state (1 = high line) |
| last_ontime | output | CNT_W | Width in clock cycles of the last completed cycle |

## Verification
The checker covers the following on every cycle:

- each gate rise is traced to an accepted start with the disable low;
- no completed pulse exceeds the budget derived from the stored on-time;
- every pulse not cut short by a disable or a restart lasts at least the minimum width and is copied into `last_ontime`;
- line edges follow the raw bit;
- line changes and idle exits leave the stored value at zero.

Some behaviour can only be shown by the bench's scenarios. These are the exact ramp sequence across consecutive cycles, the debounce lengths including a glitch that restarts the count, the immediate cut by the disable between clock edges, and the return to minimum width after each kind of restart.

// File: rtl/srl_pkg.sv
package srl_pkg;

  // Reason a conduction cycle ended; only REQ and LIMIT are recorded.
  typedef enum logic [1:0] {
    END_NONE  = 2'd0,
    END_REQ   = 2'd1,
    END_LIMIT = 2'd2,
    END_ABORT = 2'd3
  } end_cause_e;

endpackage

// File: rtl/srl_line_debounce.sv
module srl_line_debounce #(
  parameter int LH_CYC = 900000,
  parameter int HL_CYC = 750,
  parameter int TMR_W  = 21
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_raw,
  output logic line_high,
  output logic line_flip
);

  localparam logic [TMR_W-1:0] LH_LAST = TMR_W'(LH_CYC - 1);
  localparam logic [TMR_W-1:0] HL_LAST = TMR_W'(HL_CYC - 1);

  logic             line_q, line_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             tmr_en;
  logic             differ;
  logic [TMR_W-1:0] target;

  always_comb begin
    differ    = line_raw ^ line_q;
    target    = line_q ? HL_LAST : LH_LAST;
    line_flip = differ && (tmr_q == target);
    line_d    = line_q ^ line_flip;
    tmr_en    = differ || (tmr_q != '0);
    if (!differ || line_flip) tmr_d = '0;
    else                      tmr_d = tmr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= 1'b0;
      tmr_q  <= '0;
    end else begin
      line_q <= line_d;
      if (tmr_en) tmr_q <= tmr_d;
    end
  end

  assign line_high = line_q;

endmodule

// File: rtl/srl_limit_calc.sv
module srl_limit_calc #(
  parameter int CNT_W    = 10,
  parameter int STEP_CYC = 25,
  parameter int MIN_CYC  = 25
) (
  input  logic [CNT_W-1:0] last_on,
  output logic [CNT_W-1:0] limit
);

  localparam logic [CNT_W:0]   STEP_X  = (CNT_W+1)'(STEP_CYC);
  localparam logic [CNT_W:0]   CAP_X   = {1'b0, {CNT_W{1'b1}}};
  localparam logic [CNT_W-1:0] MIN_X   = CNT_W'(MIN_CYC);

  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] capped;

  always_comb begin
    sum    = {1'b0, last_on} + STEP_X;
    capped = (sum > CAP_X) ? CAP_X[CNT_W-1:0] : sum[CNT_W-1:0];
    limit  = (capped < MIN_X) ? MIN_X : capped;
  end

endmodule

// File: rtl/srl_ontime_meter.sv
module srl_ontime_meter
  import srl_pkg::*;
#(
  parameter int CNT_W   = 10,
  parameter int MIN_CYC = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             off_req,
  input  logic             dis,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit,
  output logic             gate_q,
  output logic [CNT_W-1:0] cnt,
  output end_cause_e       end_cause
);

  localparam logic [CNT_W-1:0] MIN_X = CNT_W'(MIN_CYC);

  logic             gate_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    end_cause = END_NONE;
    if (gate_q) begin
      if (dis || restart)                   end_cause = END_ABORT;
      else if (cnt_q >= limit)              end_cause = END_LIMIT;
      else if (off_req && cnt_q >= MIN_X)   end_cause = END_REQ;
    end
  end

  always_comb begin
    gate_d = gate_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (!gate_q) begin
      if (start && !dis) begin
        gate_d = 1'b1;
        cnt_d  = CNT_W'(1);
        cnt_en = 1'b1;
      end
    end else if (end_cause != END_NONE) begin
      gate_d = 1'b0;
    end else begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      gate_q <= gate_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/srl_ontime_store.sv
module srl_ontime_store
  import srl_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  end_cause_e       end_cause,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] last_on
);

  logic [CNT_W-1:0] last_q, last_d;
  logic             last_en;

  always_comb begin
    last_d  = last_q;
    last_en = 1'b0;
    if (restart) begin
      last_d  = '0;
      last_en = 1'b1;
    end else if (end_cause == END_REQ || end_cause == END_LIMIT) begin
      last_d  = cnt;
      last_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       last_q <= '0;
    else if (last_en) last_q <= last_d;
  end

  assign last_on = last_q;

endmodule

// File: rtl/srl_expansion_limiter.sv
module srl_expansion_limiter
  import srl_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int STEP_CYC = 25,
  parameter int MIN_CYC  = 25,
  parameter int LH_CYC   = 900000,
  parameter int HL_CYC   = 750
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_start,
  input  logic             off_req,
  input  logic             line_raw,
  input  logic             idle_exit,
  input  logic             gate_dis,
  output logic             gate_out,
  output logic             line_high,
  output logic [CNT_W-1:0] last_ontime
);

  localparam int DEB_MAX = (LH_CYC > HL_CYC) ? LH_CYC : HL_CYC;
  localparam int TMR_W   = $clog2(DEB_MAX + 1);

  logic             line_flip;
  logic             restart;
  logic [CNT_W-1:0] limit;
  logic             gate_q;
  logic [CNT_W-1:0] cnt;
  end_cause_e       end_cause;

  srl_line_debounce #(
    .LH_CYC(LH_CYC), .HL_CYC(HL_CYC), .TMR_W(TMR_W)
  ) u_deb (
    .clk(clk), .rst_n(rst_n), .line_raw(line_raw),
    .line_high(line_high), .line_flip(line_flip)
  );

  assign restart = line_flip | idle_exit;

  srl_limit_calc #(
    .CNT_W(CNT_W), .STEP_CYC(STEP_CYC), .MIN_CYC(MIN_CYC)
  ) u_lim (
    .last_on(last_ontime), .limit(limit)
  );

  srl_ontime_meter #(
    .CNT_W(CNT_W), .MIN_CYC(MIN_CYC)
  ) u_meter (
    .clk(clk), .rst_n(rst_n), .start(gate_start), .off_req(off_req),
    .dis(gate_dis), .restart(restart), .limit(limit),
    .gate_q(gate_q), .cnt(cnt), .end_cause(end_cause)
  );

  srl_ontime_store #(
    .CNT_W(CNT_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .restart(restart), .end_cause(end_cause),
    .cnt(cnt), .last_on(last_ontime)
  );

  // Disable cuts the gate without waiting for a clock edge.
  assign gate_out = gate_q & ~gate_dis;

endmodule

// File: rtl/srl_expansion_limiter_chk.sv
module srl_expansion_limiter_chk #(
  parameter int CNT_W    = 10,
  parameter int STEP_CYC = 25,
  parameter int MIN_CYC  = 25
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gate_start,
  input logic             gate_dis,
  input logic             idle_exit,
  input logic             line_raw,
  input logic             gate_out,
  input logic             line_high,
  input logic [CNT_W-1:0] last_ontime
);

  logic [CNT_W:0]   wc;
  logic [CNT_W-1:0] last_d;
  logic [CNT_W+1:0] bound;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wc     <= '0;
      last_d <= '0;
    end else begin
      last_d <= last_ontime;
      if (gate_out) wc <= wc + 1'b1;
      else          wc <= '0;
    end
  end

  always_comb begin
    bound = (CNT_W+2)'(last_d) + (CNT_W+2)'(STEP_CYC);
    if (bound < (CNT_W+2)'(MIN_CYC)) bound = (CNT_W+2)'(MIN_CYC);
  end

  // R2: every rise follows an accepted start with disable low
  assert_rise_from_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_out) |-> ($past(gate_start) && !$past(gate_dis)));

  // R3: completed pulse width never beyond the budget
  assert_width_budget_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_out) |-> ((CNT_W+2)'(wc) <= bound));

  // R5: undisturbed pulses reach the minimum width
  assert_min_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(gate_out) && !gate_dis && !$past(gate_dis) && !$past(idle_exit) && $stable(line_high))
      |-> (wc >= (CNT_W+1)'(MIN_CYC)));

  // R7: undisturbed pulses are recorded
  assert_record_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(gate_out) && !gate_dis && !$past(gate_dis) && !$past(idle_exit) && $stable(line_high))
      |-> ((CNT_W+1)'(last_ontime) == wc));

  // R8: rise of line state only on raw high samples
  assert_line_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_high) |-> $past(line_raw));

  // R9: fall of line state only on raw low samples
  assert_line_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_high) |-> !$past(line_raw));

  // R10: line change clears stored on-time
  assert_line_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(line_high) || $fell(line_high)) |-> (last_ontime == '0));

  // R11: idle exit clears stored on-time
  assert_idle_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(idle_exit) |-> (last_ontime == '0));

endmodule

bind srl_expansion_limiter srl_expansion_limiter_chk #(
  .CNT_W(CNT_W), .STEP_CYC(STEP_CYC), .MIN_CYC(MIN_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .gate_start(gate_start), .gate_dis(gate_dis),
  .idle_exit(idle_exit), .line_raw(line_raw), .gate_out(gate_out),
  .line_high(line_high), .last_ontime(last_ontime)
);

// File: tb/sim_srl_expansion_limiter.sv
module sim_srl_expansion_limiter;

  localparam int CNT_W = 10;
  localparam int STEP  = 25;
  localparam int MINW  = 25;
  localparam int LH    = 300;
  localparam int HL    = 12;
  localparam int NV    = 8;
  // off_req after N high samples (0 = never) and expected width
  localparam int V_OFF [NV] = '{0, 0, 30, 10, 0, 60, 0, 200};
  localparam int V_EXP [NV] = '{25, 50, 30, 25, 50, 60, 85, 110};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gate_start = 1'b0, off_req = 1'b0, line_raw = 1'b0;
  logic idle_exit = 1'b0, gate_dis = 1'b0;
  logic gate_out, line_high;
  logic [CNT_W-1:0] last_ontime;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  srl_expansion_limiter #(
    .CNT_W(CNT_W), .STEP_CYC(STEP), .MIN_CYC(MINW), .LH_CYC(LH), .HL_CYC(HL)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .gate_start(gate_start), .off_req(off_req),
    .line_raw(line_raw), .idle_exit(idle_exit), .gate_dis(gate_dis),
    .gate_out(gate_out), .line_high(line_high), .last_ontime(last_ontime)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One conduction cycle; returns measured width.
  task automatic run_cycle(input int off_after, output int w);
    gate_start = 1'b1;
    @(negedge clk);
    gate_start = 1'b0;
    w = 0;
    while (gate_out && w < 1000) begin
      w++;
      if (off_after != 0 && w == off_after) off_req = 1'b1;
      @(negedge clk);
    end
    off_req = 1'b0;
  endtask

  initial begin
    int w;
    repeat (3) @(negedge clk);
    chk("R1 gate in reset", int'(gate_out), 0);
    chk("R1 line in reset", int'(line_high), 0);
    chk("R1 last in reset", int'(last_ontime), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 gate after reset", int'(gate_out), 0);

    // Table of ramp vectors: covers R3 budget, R4 request, R5 minimum, R7 record
    for (int i = 0; i < NV; i++) begin
      run_cycle(V_OFF[i], w);
      chk((V_OFF[i] == 0) ? "R3 budget width" :
          (V_OFF[i] < MINW) ? "R5 minimum width" : "R4 request width", w, V_EXP[i]);
      chk("R7 stored width", int'(last_ontime), V_EXP[i]);
      repeat (3) @(negedge clk);
    end

    // R11 idle exit clears and restarts ramp
    idle_exit = 1'b1;
    @(negedge clk);
    idle_exit = 1'b0;
    chk("R11 cleared on idle exit", int'(last_ontime), 0);
    run_cycle(0, w);
    chk("R11 soft start width", w, MINW);

    // R6 disable mid-cycle
    gate_start = 1'b1;
    @(negedge clk);
    gate_start = 1'b0;
    repeat (9) @(negedge clk);
    gate_dis = 1'b1;
    #1;
    chk("R6 immediate cut", int'(gate_out), 0);
    @(negedge clk);
    gate_dis = 1'b0;
    @(negedge clk);
    chk("R6 gate stays low", int'(gate_out), 0);
    chk("R6 no record", int'(last_ontime), MINW);

    // R2 start ignored while disabled
    gate_dis = 1'b1;
    gate_start = 1'b1;
    @(negedge clk);
    gate_start = 1'b0;
    @(negedge clk);
    gate_dis = 1'b0;
    @(negedge clk);
    chk("R2 start ignored when disabled", int'(gate_out), 0);

    // R8 glitch restarts count
    line_raw = 1'b1;
    repeat (LH - 50) @(negedge clk);
    line_raw = 1'b0;
    @(negedge clk);
    line_raw = 1'b1;
    repeat (LH - 1) @(negedge clk);
    chk("R8 still low before full run", int'(line_high), 0);
    @(negedge clk);
    chk("R8 high after full run", int'(line_high), 1);
    chk("R10 cleared on rise", int'(last_ontime), 0);
    run_cycle(0, w);
    chk("R10 minimum after change", w, MINW);
    repeat (2) @(negedge clk);

    // R9 high to low
    line_raw = 1'b0;
    repeat (HL - 1) @(negedge clk);
    chk("R9 still high before run", int'(line_high), 1);
    @(negedge clk);
    chk("R9 low after run", int'(line_high), 0);
    chk("R10 cleared on fall", int'(last_ontime), 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    fails++;
    $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule